// File: doc/BRIEF.md
# Fixed-Width Pulse Repeater with Duty-Cycle Limit

This block takes a single raw, asynchronous pulse input, cleans it, and regenerates it on a 20 MHz clock. The input first crosses into the clock domain through a two-flop synchroniser. A glitch filter then accepts a new level only once that level has been seen for a programmable number of consecutive cycles.

In fixed-width mode, every rising edge of the filtered level fires an output pulse that lasts an exact number of clock cycles. The block then ignores further triggers for a hold-off window. The pulse and the hold-off together occupy a whole number of pulse widths, so the output duty cycle can never exceed one over the divider. Edges that arrive while the block is busy are dropped and are never remembered.

In pass-through mode, chosen by a compile-time parameter, the filtered level drives the output directly. The width and divider parameters then have no effect. All ports are active-high. In fixed-width mode, a pulse width outside 20 to 40 cycles (1 to 2 µs) stops elaboration with an error. A divider or filter length below one also stops elaboration.

Top module: `pulse_repeater`

## Requirements
- R1: While `rst_i` is high, and in the cycle after it is sampled high, `pulse_o` and `busy_o` are 0. Reset abandons any active pulse or hold-off, even one already in progress.
- R2: A change of the raw input reaches the filtered level only if the synchronised input holds the new value for FILT_LEN consecutive cycles. An input pulse shorter than FILT_LEN cycles produces no output in either mode.
- R3: In fixed-width mode, `pulse_o` rises on the clock edge 3 + FILT_LEN edges after the first edge that samples a qualifying raw rising edge. That count is 2 synchroniser stages, FILT_LEN filter edges and 1 edge-detect/shaper edge.
- R4: In fixed-width mode, each output pulse is high for exactly PULSE_CYCLES cycles, whether the input pulse is shorter or longer than that.
- R5: In fixed-width mode, `busy_o` rises together with `pulse_o`. It stays high through the pulse and the hold-off, and falls exactly RATE_DIV × PULSE_CYCLES cycles after the pulse rose.
- R6: A filtered rising edge that occurs while `busy_o` is high is discarded and never fires a pulse later. An edge that reaches the filtered level while the block is idle fires a pulse on the next cycle. The earliest accepted start is therefore RATE_DIV × PULSE_CYCLES + 1 cycles after the previous start.
- R7: In pass-through mode (FIXED_WIDTH = 0), `pulse_o` equals the filtered level. It rises 2 + FILT_LEN edges after the first edge that samples the input, and it is exactly as wide as the input pulse. `busy_o` stays 0, and PULSE_CYCLES and RATE_DIV have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 20 MHz clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pulse_i | input | 1 | Raw asynchronous pulse input |
| pulse_o | output | 1 | Regenerated (or passed-through) pulse |
| busy_o | output | 1 | High during an output pulse and its hold-off window |

## Verification
Every cycle, the embedded properties check four things. The filtered level may only move to a value the synchroniser presented. A fixed-width pulse never runs longer than PULSE_CYCLES and always ends at exactly that length. The busy flag starts with each pulse, and the period counter stays inside its window. Only the bench scenarios can show the rest: the end-to-end latency from the raw input, the dropping of short glitches, and the rejection of edges inside the hold-off with no late firing afterwards. They also show the exact one-cycle boundary where a new edge becomes acceptable, recovery from a reset in mid-pulse, and that pass-through output matches the input width.

// File: rtl/pr_pkg.sv
package pr_pkg;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_PULSE = 2'd1,
        SH_HOLD  = 2'd2
    } sh_state_e;

endpackage

// File: rtl/pr_sync.sv
module pr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic din_i,
    output logic dout_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign dout_o = chain_q[STAGES-1];

endmodule

// File: rtl/pr_glitch_filter.sv
module pr_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic din_i,
    output logic level_o
);

    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din_i == st_q.level) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.level = din_i;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign level_o = st_q.level;

    // R2
    level_source_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(st_q.level) |-> st_q.level == $past(din_i));

    // R2
    filt_cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= CNT_LAST);

endmodule

// File: rtl/pr_shaper.sv
module pr_shaper
    import pr_pkg::*;
#(
    parameter int PULSE_CYCLES = 24,
    parameter int RATE_DIV     = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic pulse_o,
    output logic busy_o
);

    localparam int PERIOD = RATE_DIV * PULSE_CYCLES;
    localparam int CW     = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] PW_LAST  = CW'(PULSE_CYCLES - 1);
    localparam logic [CW-1:0] PER_LAST = CW'(PERIOD - 1);
    localparam bit HOLD_EN = (RATE_DIV > 1);

    typedef struct packed {
        sh_state_e     state;
        logic          prev;
        logic [CW-1:0] cnt;
    } sh_t;

    sh_t  st_d, st_q;
    logic rise;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        rise      = level_i & ~st_q.prev;
        case (st_q.state)
            SH_IDLE: begin
                if (rise) begin
                    st_d.state = SH_PULSE;
                    st_d.cnt   = '0;
                end
            end
            SH_PULSE: begin
                if (st_q.cnt == PW_LAST) begin
                    if (HOLD_EN) begin
                        st_d.state = SH_HOLD;
                        st_d.cnt   = st_q.cnt + CW'(1);
                    end else begin
                        st_d.state = SH_IDLE;
                        st_d.cnt   = '0;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            SH_HOLD: begin
                if (st_q.cnt == PER_LAST) begin
                    st_d.state = SH_IDLE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            default: begin
                st_d.state = SH_IDLE;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '{state: SH_IDLE, prev: 1'b0, cnt: '0};
        else       st_q <= st_d;
    end

    assign pulse_o = (st_q.state == SH_PULSE);
    assign busy_o  = (st_q.state != SH_IDLE);

    logic [CW-1:0] run_q;
    always_ff @(posedge clk_i) begin
        if (rst_i)        run_q <= '0;
        else if (pulse_o) run_q <= run_q + CW'(1);
        else              run_q <= '0;
    end

    // R4
    width_max_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> run_q < CW'(PULSE_CYCLES));

    // R4
    width_exact_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pulse_o) |-> run_q == CW'(PULSE_CYCLES));

    // R5
    busy_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> $rose(pulse_o));

    // R5
    period_cnt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= PER_LAST);

endmodule

// File: rtl/pulse_repeater.sv
module pulse_repeater #(
    parameter bit FIXED_WIDTH  = 1'b1,
    parameter int PULSE_CYCLES = 24,
    parameter int RATE_DIV     = 2,
    parameter int FILT_LEN     = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pulse_i,
    output logic pulse_o,
    output logic busy_o
);

    localparam int SYNC_STAGES = 2;

    if (FIXED_WIDTH && (PULSE_CYCLES < 20 || PULSE_CYCLES > 40)) begin : g_bad_width
        $error("pulse_repeater: PULSE_CYCLES must lie in 20..40");
    end
    if (RATE_DIV < 1 || FILT_LEN < 1) begin : g_bad_cfg
        $error("pulse_repeater: RATE_DIV and FILT_LEN must be at least 1");
    end

    logic sync_lvl;
    logic filt_lvl;

    pr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .din_i  (pulse_i),
        .dout_o (sync_lvl)
    );

    pr_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .din_i   (sync_lvl),
        .level_o (filt_lvl)
    );

    if (FIXED_WIDTH) begin : g_fixed
        pr_shaper #(
            .PULSE_CYCLES (PULSE_CYCLES),
            .RATE_DIV     (RATE_DIV)
        ) u_shaper (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .level_i (filt_lvl),
            .pulse_o (pulse_o),
            .busy_o  (busy_o)
        );
    end else begin : g_pass
        assign pulse_o = filt_lvl;
        assign busy_o  = 1'b0;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!pulse_o && !busy_o));

endmodule

// File: tb/tb_pulse_repeater.sv
module tb_pulse_repeater;

    localparam int F   = 4;
    localparam int PW  = 24;
    localparam int DIV = 2;
    localparam int P   = PW * DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin = 1'b0;
    logic pout, busy, pout_p, busy_p;

    pulse_repeater #(.FIXED_WIDTH(1'b1), .PULSE_CYCLES(PW), .RATE_DIV(DIV), .FILT_LEN(F)) dut (
        .clk_i(clk), .rst_i(rst), .pulse_i(pin), .pulse_o(pout), .busy_o(busy));

    pulse_repeater #(.FIXED_WIDTH(1'b0), .PULSE_CYCLES(PW), .RATE_DIV(DIV), .FILT_LEN(F)) dut_pass (
        .clk_i(clk), .rst_i(rst), .pulse_i(pin), .pulse_o(pout_p), .busy_o(busy_p));

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int start;
        int width;
    } exp_t;

    exp_t q_fix[$];
    exp_t q_pass[$];
    int n_chk = 0;
    int n_fail = 0;
    int last_start = -100000;
    int pulses_fix = 0;
    int pulses_pass = 0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // Driver: predicts the expected output pulses, then drives the input.
    task automatic drive(input int len, input int gap);
        int c;
        int cand;
        exp_t e;
        @(negedge clk);
        c = cyc;
        if (len >= F) begin
            cand = c + 3 + F;
            if (cand > last_start + P) begin
                e.start = cand; e.width = PW;
                q_fix.push_back(e);
                last_start = cand;
            end
            e.start = c + 2 + F; e.width = len;
            q_pass.push_back(e);
        end
        pin = 1'b1;
        repeat (len) @(negedge clk);
        pin = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // Monitor: measures pulses and compares them with the queues.
    logic pf_prev = 1'b0, bf_prev = 1'b0, pp_prev = 1'b0;
    int rise_f = 0, rise_p = 0;
    always @(negedge clk) begin
        exp_t e;
        if (rst) begin
            pf_prev = 1'b0; bf_prev = 1'b0; pp_prev = 1'b0;
        end else begin
            if (pout && !pf_prev) begin
                rise_f = cyc;
                pulses_fix++;
                check(busy == 1'b1, "R5 busy with pulse start", busy, 1);
            end
            if (!pout && pf_prev) begin
                if (q_fix.size() == 0) begin
                    check(1'b0, "R6 unexpected fixed pulse", rise_f, -1);
                end else begin
                    e = q_fix.pop_front();
                    check(rise_f == e.start, "R3 fixed pulse start", rise_f, e.start);
                    check(cyc - rise_f == e.width, "R4 fixed pulse width", cyc - rise_f, e.width);
                end
            end
            if (!busy && bf_prev)
                check(cyc == rise_f + P, "R5 busy fall cycle", cyc, rise_f + P);
            if (pout_p && !pp_prev) begin
                rise_p = cyc;
                pulses_pass++;
                check(busy_p == 1'b0, "R7 pass busy low", busy_p, 0);
            end
            if (!pout_p && pp_prev) begin
                if (q_pass.size() == 0) begin
                    check(1'b0, "R7 unexpected pass pulse", rise_p, -1);
                end else begin
                    e = q_pass.pop_front();
                    check(rise_p == e.start, "R7 pass pulse start", rise_p, e.start);
                    check(cyc - rise_p == e.width, "R7 pass pulse width", cyc - rise_p, e.width);
                end
            end
            pf_prev = pout; bf_prev = busy; pp_prev = pout_p;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int before_f;
        int before_p;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pout == 1'b0, "R1 reset pulse_o", pout, 0);
        check(busy == 1'b0, "R1 reset busy_o", busy, 0);
        check(pout_p == 1'b0, "R1 reset pass pulse_o", pout_p, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R3 R4 R7: basic short input
        drive(10, 60);

        // R2: glitch shorter than the filter length is dropped
        before_f = pulses_fix;
        before_p = pulses_pass;
        drive(F - 1, 60);
        check(pulses_fix == before_f, "R2 glitch fixed", pulses_fix, before_f);
        check(pulses_pass == before_p, "R2 glitch pass", pulses_pass, before_p);

        // R4 R7: long input, fixed width still PW
        drive(60, 60);

        // R6: second edge inside hold-off is discarded, not queued
        before_f = pulses_fix;
        drive(5, 10);
        drive(5, 60);
        check(pulses_fix == before_f + 1, "R6 edge in hold-off dropped", pulses_fix, before_f + 1);

        // R6: boundary, edge one cycle too early is rejected
        before_f = pulses_fix;
        drive(5, P - 6);
        drive(5, 60);
        check(pulses_fix == before_f + 1, "R6 boundary early rejected", pulses_fix, before_f + 1);

        // R6: boundary, earliest acceptable edge fires
        before_f = pulses_fix;
        drive(5, P - 5);
        drive(5, 60);
        check(pulses_fix == before_f + 2, "R6 boundary accepted", pulses_fix, before_f + 2);

        // R1: reset in the middle of a pulse
        @(negedge clk);
        pin = 1'b1;
        while (!pout) @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        pin = 1'b0;
        @(negedge clk);
        check(pout == 1'b0, "R1 mid-pulse reset pulse_o", pout, 0);
        check(busy == 1'b0, "R1 mid-pulse reset busy_o", busy, 0);
        check(pout_p == 1'b0, "R1 mid-pulse reset pass", pout_p, 0);
        @(negedge clk);
        q_fix.delete();
        q_pass.delete();
        last_start = -100000;
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 R3: normal operation after reset
        drive(10, 80);

        check(q_fix.size() == 0, "R3 all fixed pulses seen", q_fix.size(), 0);
        check(q_pass.size() == 0, "R7 all pass pulses seen", q_pass.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule